// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 16-bit words with separate upper and lower byte selects. The host offers one request at a time: a word address, a read/write flag, write data and a two-bit lane mask. The controller turns each request into a sequence of chip-select, write-enable, output-enable and lane-select levels on the memory pins. For reads it returns the captured word with a one-cycle valid pulse.

All memory timing is set by parameters given in nanoseconds, together with the clock period. Each interval becomes a whole number of clock cycles: the quotient is rounded up, and it is never less than one. Writes are timed by the write-enable strobe. Reads are timed by the output-enable strobe. The data bus is driven through a registered drive-enable, and its turnaround after a read is enforced. Between accesses the memory is left deselected, with every strobe inactive.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, chip select, write enable, output enable and both lane selects are high, the drive-enable is low, and `req_ready` is high.
- R2: A write drives the address, chip select low, the lane selects and the drive-enable in the cycle after acceptance, with write enable still high. Mask bit 0 selects the lower byte (bits 7:0, `mem_lb_n`); mask bit 1 selects the upper byte (bits 15:8, `mem_ub_n`).
- R3: Write enable is low only while chip select is low and output enable is high.
- R4: Write enable stays low for PULSE = max(ceil(T_WP/CLK), ceil(T_AW/CLK)-1, ceil(T_DW/CLK)-1, ceil(T_WC/CLK)-2) cycles, where each ceil is at least 1. Write enable therefore rises no sooner than T_WP after it falls, T_DW after the data is set, and T_AW after the address and chip select are set.
- R5: Address and lane selects do not change while write enable is low.
- R6: The drive-enable rises one cycle before write enable falls. It is still high in the cycle write enable rises, and low in the next cycle.
- R7: A read holds chip select and output enable low, write enable high and the lane selects per the mask for RD = max(ceil(T_AA/CLK), ceil(T_OE/CLK), ceil(T_RC/CLK)) cycles. It captures the bus at the end of that time, so `rsp_valid` is high for exactly one cycle, RD+1 cycles after the accepting edge.
- R8: In returned read data, lanes whose mask bit is 0 read as zero.
- R9: The drive-enable is never high while output enable is low. After output enable rises, the drive-enable does not rise until at least ceil(T_HZ/CLK) cycles have passed.
- R10: `req_ready` is high only in idle, and a request is taken when `req_valid` and `req_ready` are both high. `req_ready` returns PULSE+3 cycles after a write is accepted, and RD+HZ+1 cycles after a read is accepted.
- R11: A write with one mask bit clear leaves that byte of the addressed word unchanged in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_data | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive-enable |
| mem_dq_in | input | DATA_W | Data read from the bus |

## Verification
The assertions assume a host that keeps `req_valid` and the request fields steady until the request is accepted. They also assume the memory takes no part in the strobe sequencing beyond returning data on `mem_dq_in`. The bench keeps to this by presenting fields only at the falling clock edge and holding them until an accept edge has passed. It resolves the bus from the drive-enable and a behavioural memory model. That model times each write strobe and read capture against the nanosecond limits in simulated time. It also flags bus contention, so timing errors appear even where the cycle counts look right.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_TURN   = 3'd5
  } lane_state_e;

  // Whole clock cycles covering a nanosecond interval, never below one.
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val - CNT_W'(1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_load,
  input  logic              wr_load,
  input  logic              lane_release,
  input  logic              drive_d,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [LANES-1:0]  in_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  lane_n_q,
  output logic [DATA_W-1:0] dq_out_q,
  output logic              dq_oe_q,
  output logic [DATA_W-1:0] rd_data_q,
  output logic              rd_valid_q
);

  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] rd_masked;

  // Unselected lanes float on the bus; return them as zero.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_masked[g*LANE_W +: LANE_W] =
      lane_n_q[g] ? '0 : dq_in[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      lane_n_q <= '1;
    end else begin
      if (acc_load) begin
        addr_q   <= in_addr;
        lane_n_q <= ~in_mask;
      end else if (lane_release) begin
        lane_n_q <= '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out_q <= '0;
      dq_oe_q  <= 1'b0;
    end else begin
      if (wr_load) dq_out_q <= in_wdata;
      dq_oe_q <= drive_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= capture;
      if (capture) rd_data_q <= rd_masked;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int CLK_NS = 10,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 35,
  parameter int T_DW_NS = 25,
  parameter int T_AW_NS = 40,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_OE_NS = 25,
  parameter int T_HZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int N_WP    = ns_to_cycles(T_WP_NS, CLK_NS);
  localparam int N_DW    = ns_to_cycles(T_DW_NS, CLK_NS);
  localparam int N_AW    = ns_to_cycles(T_AW_NS, CLK_NS);
  localparam int N_WC    = ns_to_cycles(T_WC_NS, CLK_NS);
  localparam int N_AA    = ns_to_cycles(T_AA_NS, CLK_NS);
  localparam int N_OE    = ns_to_cycles(T_OE_NS, CLK_NS);
  localparam int N_RC    = ns_to_cycles(T_RC_NS, CLK_NS);
  localparam int N_HZ    = ns_to_cycles(T_HZ_NS, CLK_NS);
  // Setup cycle already gives address/data one cycle of lead; hold cycle adds one to the cycle time.
  localparam int N_PULSE = imax(imax(N_WP, N_AW - 1), imax(N_DW - 1, N_WC - 2));
  localparam int N_RD    = imax(imax(N_AA, N_OE), N_RC);
  localparam int N_MAX   = imax(imax(N_PULSE, N_RD), N_HZ);
  localparam int CNT_W   = $clog2(N_MAX + 1);

  lane_state_e      state_q, state_d;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, capture, lane_release;
  logic             cs_n_d, we_n_d, oe_n_d, drive_d;
  logic [1:0]       lane_n;

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_ready && req_valid;
  assign capture      = (state_q == ST_RACC) && tmr_exp;
  assign lane_release = ((state_q == ST_WHOLD) || (state_q == ST_RACC)) && tmr_exp;

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  // Next-state and interval selection
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(1);
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WSETUP;
            tmr_val = CNT_W'(1);
          end else begin
            state_d = ST_RACC;
            tmr_val = CNT_W'(N_RD);
          end
        end
      end
      ST_WSETUP: begin
        if (tmr_exp) begin
          state_d  = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(N_PULSE);
        end
      end
      ST_WPULSE: begin
        if (tmr_exp) begin
          state_d  = ST_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(1);
        end
      end
      ST_WHOLD: begin
        if (tmr_exp) state_d = ST_IDLE;
      end
      ST_RACC: begin
        if (tmr_exp) begin
          state_d  = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(N_HZ);
        end
      end
      ST_TURN: begin
        if (tmr_exp) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobe levels decoded from the next state, then registered
  always_comb begin
    cs_n_d  = !((state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
                (state_d == ST_WHOLD)  || (state_d == ST_RACC));
    we_n_d  = (state_d != ST_WPULSE);
    oe_n_d  = (state_d != ST_RACC);
    drive_d = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
    end else begin
      state_q  <= state_d;
      mem_cs_n <= cs_n_d;
      mem_we_n <= we_n_d;
      mem_oe_n <= oe_n_d;
    end
  end

  sram_lane_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(2)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_load     (accept),
    .wr_load      (accept && req_write),
    .lane_release (lane_release),
    .drive_d      (drive_d),
    .capture      (capture),
    .in_addr      (req_addr),
    .in_wdata     (req_wdata),
    .in_mask      (req_be),
    .dq_in        (mem_dq_in),
    .addr_q       (mem_addr),
    .lane_n_q     (lane_n),
    .dq_out_q     (mem_dq_out),
    .dq_oe_q      (mem_dq_oe),
    .rd_data_q    (rsp_data),
    .rd_valid_q   (rsp_valid)
  );

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];

  // ---------------- assertions ----------------
  logic [CNT_W:0] we_lo_q;
  logic [CNT_W:0] oe_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_q <= '0;
      oe_hi_q <= '1;
    end else begin
      if (!mem_we_n) we_lo_q <= (we_lo_q == '1) ? we_lo_q : we_lo_q + 1'b1;
      else           we_lo_q <= '0;
      if (!mem_oe_n) oe_hi_q <= '0;
      else           oe_hi_q <= (oe_hi_q == '1) ? oe_hi_q : oe_hi_q + 1'b1;
    end
  end

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (mem_cs_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

  p_we_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(we_lo_q) >= N_WP));

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> (mem_we_n || ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n))));

  p_drive_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (mem_dq_oe && $past(mem_dq_oe)));

  p_drive_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  p_drive_trail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

  p_read_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (int'(oe_hi_q) >= N_HZ));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !rsp_valid));

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int TWC = 55, TWP = 35, TDW = 25, TAW = 40;
  localparam int TRC = 55, TAA = 55, TOE = 25, THZ = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PULSE = mx(mx(cyc(TWP), cyc(TAW) - 1), mx(cyc(TDW) - 1, cyc(TWC) - 2));
  localparam int E_RD    = mx(mx(cyc(TAA), cyc(TOE)), cyc(TRC));
  localparam int E_HZ    = cyc(THZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD),
    .T_WC_NS(TWC), .T_WP_NS(TWP), .T_DW_NS(TDW), .T_AW_NS(TAW),
    .T_RC_NS(TRC), .T_AA_NS(TAA), .T_OE_NS(TOE), .T_HZ_NS(THZ)
  ) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [DW-1:0] mem_arr [DEPTH];
  logic [DW-1:0] ref_arr [DEPTH];
  logic rd_drv;
  realtime t_we_fall = 0, t_addr = 0, t_cs_fall = 0, t_data = 0, t_oe_fall = 0;
  realtime t_oe_rise = -1000;

  assign rd_drv = !mem_cs_n && !mem_oe_n && mem_we_n;
  // Undriven lanes float high
  assign mem_dq_in = mem_dq_oe ? mem_dq_out :
    { (rd_drv && !mem_ub_n) ? mem_arr[mem_addr][15:8] : 8'hFF,
      (rd_drv && !mem_lb_n) ? mem_arr[mem_addr][7:0]  : 8'hFF };

  always @(negedge mem_we_n) t_we_fall = $realtime;
  always @(mem_addr)         t_addr    = $realtime;
  always @(negedge mem_cs_n) t_cs_fall = $realtime;
  always @(mem_dq_out)       t_data    = $realtime;
  always @(negedge mem_oe_n) t_oe_fall = $realtime;
  always @(posedge mem_oe_n) t_oe_rise = $realtime;

  // Write ends on the rising write strobe: check its timing, then store the lanes
  always @(posedge mem_we_n) begin
    if (rst_n && !mem_cs_n) begin
      chk(($realtime - t_we_fall) >= TWP, "R4 write pulse ns", int'($realtime - t_we_fall), TWP);
      chk(($realtime - t_data) >= TDW, "R4 data before write end ns", int'($realtime - t_data), TDW);
      chk(($realtime - ((t_addr > t_cs_fall) ? t_addr : t_cs_fall)) >= TAW,
          "R4 address/select before write end ns", 0, TAW);
      chk(mem_dq_oe == 1'b1, "R6 drive held at write end", mem_dq_oe, 1);
      if (!mem_lb_n) mem_arr[mem_addr][7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) mem_arr[mem_addr][15:8] = mem_dq_out[15:8];
    end
  end

  always @(posedge mem_dq_oe) begin
    if (rst_n)
      chk(($realtime - t_oe_rise) >= THZ, "R9 bus turnaround ns", int'($realtime - t_oe_rise), THZ);
  end

  always @(negedge clk) begin
    if (rst_n && mem_dq_oe && rd_drv) chk(1'b0, "R9 bus contention", 1, 0);
  end

  // ---------------- host side ----------------
  task automatic check_standby(input string tag);
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe && req_ready,
        tag, {mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 7'b1111101);
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 2'b00; req_wdata = '0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    int k, we_lo, ready_at;
    bit prev_we;
    issue(1'b1, a, d, be);
    // R2: setup cycle
    chk(!mem_cs_n && mem_we_n && mem_dq_oe && (mem_addr == a) &&
        (mem_lb_n == !be[0]) && (mem_ub_n == !be[1]) && (mem_dq_out == d),
        "R2 write setup cycle", {mem_cs_n, mem_we_n, mem_dq_oe, mem_ub_n, mem_lb_n},
        {1'b0, 1'b1, 1'b1, !be[1], !be[0]});
    k = 1; we_lo = 0; prev_we = 1'b1; ready_at = 0;
    while (ready_at == 0 && k < 100) begin
      if (!mem_we_n) we_lo++;
      if (!prev_we && mem_we_n) chk(mem_dq_oe, "R6 drive on in rise cycle", mem_dq_oe, 1);
      if (req_ready) ready_at = k;
      prev_we = mem_we_n;
      if (ready_at == 0) begin @(negedge clk); k++; end
    end
    chk(we_lo == E_PULSE, "R4 write low cycles", we_lo, E_PULSE);
    chk(ready_at == E_PULSE + 3, "R10 write busy time", ready_at, E_PULSE + 3);
    check_standby("R1 standby after write");
    if (be[0]) ref_arr[a][7:0]  = d[7:0];
    if (be[1]) ref_arr[a][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] be, input string tag);
    int k, lat, ready_at, nvalid;
    logic [DW-1:0] exp_d;
    realtime t_cap;
    issue(1'b0, a, '0, be);
    chk(!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe && (mem_addr == a) &&
        (mem_lb_n == !be[0]) && (mem_ub_n == !be[1]),
        "R7 read strobes", {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n},
        {1'b0, 1'b0, 1'b1, !be[1], !be[0]});
    exp_d = {be[1] ? ref_arr[a][15:8] : 8'h00, be[0] ? ref_arr[a][7:0] : 8'h00};
    k = 1; lat = 0; ready_at = 0; nvalid = 0;
    while (ready_at == 0 && k < 100) begin
      if (rsp_valid) begin
        nvalid++;
        lat = k;
        t_cap = $realtime - CLK_PERIOD / 2;
        chk((t_cap - t_oe_fall) >= mx(TAA, TOE), "R7 capture after access ns",
            int'(t_cap - t_oe_fall), mx(TAA, TOE));
        chk(rsp_data == exp_d, tag, rsp_data, exp_d);
      end
      if (req_ready) ready_at = k;
      if (ready_at == 0) begin @(negedge clk); k++; end
    end
    chk((lat == E_RD + 1) && (nvalid == 1), "R7 read latency and single pulse", lat, E_RD + 1);
    chk(ready_at == E_RD + E_HZ + 1, "R10 read busy time", ready_at, E_RD + E_HZ + 1);
    check_standby("R1 standby after read");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_arr[i] = 16'(i * 16'h0F1D + 16'h3C00);
      ref_arr[i] = 16'(i * 16'h0F1D + 16'h3C00);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_standby("R1 reset state");

    // Requests held off while busy: second request waits for ready (R10)
    do_write(4'd3, 16'hBEEF, 2'b11);
    do_read(4'd3, 2'b11, "R11 full word readback");

    // Sweep every address and every lane mask
    for (int a = 0; a < DEPTH; a++) begin
      for (int m = 0; m < 4; m++) begin
        do_write(AW'(a), 16'((a * 16'h0123 + m * 16'h1010) ^ 16'h5A5A), 2'(m));
        for (int r = 0; r < 4; r++)
          do_read(AW'(a), 2'(r), (r == 3) ? "R11 partial write preserves other lane"
                                          : "R8 unselected lanes read zero");
      end
    end

    // Mixed randomised traffic
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] ra;
      logic [1:0] rb;
      ra = AW'($urandom);
      rb = 2'($urandom);
      if ($urandom % 2 == 1) do_write(ra, 16'($urandom), rb);
      else                   do_read(ra, rb, "R8 random read data");
    end

    // Back-to-back read then write exercises turnaround (R9)
    do_read(4'd7, 2'b01, "R8 lower lane only");
    do_write(4'd7, 16'h1234, 2'b10);
    do_read(4'd7, 2'b11, "R11 upper written, lower kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule